// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between a PWM generator and the pins that drive a power stage. It takes raw high-side and low-side PWM drive signals, applies a per-side output polarity, and can override every pin with its inactive level when a fault is reported. Two active-low fault inputs, A and B, are watched. Because they are active-low, several open-drain sources can share one line.

Each fault has its own enable and its own recovery mode. In latched mode a fault holds the outputs off until the line is high again and software has cleared the fault's status flag. In cycle-by-cycle mode the outputs are held off only while the line is low, and the flag clears by itself. In both modes the outputs come back only at a period-start strobe from the PWM counter, so a partial pulse is never emitted.

The shutdown itself acts through a combinational path straight from the fault pin, with no clock edge in the way. The status flags and the recovery state come from a synchronized copy of each fault line. A reset option chooses whether the pin output enables come up all set or all cleared (tri-stated).

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset `flt_stat` is 0, and `pin_oe` is all zeros when `OE_ON_RESET` is 0 or all ones when it is 1. A cycle with `oe_wr` high loads `oe_val` into `pin_oe` at that clock edge. Bits [N-1:0] of `pin_oe` are the high side and bits [2N-1:N] are the low side.
- R2: When no enabled fault is active, `pin_hi[i]` equals `pwm_hi_in[i] ^ hi_act_low` and `pin_lo[i]` equals `pwm_lo_in[i] ^ lo_act_low`.
- R3: When an enabled fault line is low, every `pin_hi` equals `hi_act_low` and every `pin_lo` equals `lo_act_low` in the same cycle, before any clock edge.
- R4: A fault whose enable bit is 0 has no effect on the pins, and its status flag stays 0.
- R5: A fault line held low while it is enabled sets its status flag no later than SYNC_STAGES+1 clock edges after it falls.
- R6: In latched mode, a status-clear request made while the fault line is still low is ignored: the flag stays 1 and the pins stay inactive.
- R7: In latched mode, after the line is high and the flag has been cleared, the pins stay inactive until the next clock edge at which `period_start` is high, and resume normal drive after that edge.
- R8: In latched mode, a high line followed by a period start, with no status clear, does not release the pins.
- R9: In cycle-by-cycle mode, the pins stay inactive while the line is low, even across period starts. After the line goes high, the first period-start edge both clears the flag and restores normal drive.
- R10: When both faults are active, the pins stay inactive until each fault has met its own release condition.
- R11: Index 0 of `flt_en`, `flt_cbc`, `stat_clr` and `flt_stat` belongs to fault A, and index 1 to fault B. A value of 1 in `flt_cbc` selects cycle-by-cycle mode and 0 selects latched mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_hi_in | input | NUM_PAIRS | Raw high-side drive, 1 = on |
| pwm_lo_in | input | NUM_PAIRS | Raw low-side drive, 1 = on |
| period_start | input | 1 | One-cycle strobe at each PWM period start |
| hi_act_low | input | 1 | High-side polarity, 1 = active-low pins |
| lo_act_low | input | 1 | Low-side polarity, 1 = active-low pins |
| flt_a_n | input | 1 | Fault A line, active-low |
| flt_b_n | input | 1 | Fault B line, active-low |
| flt_en | input | 2 | Fault enables (bit 0 = A, bit 1 = B) |
| flt_cbc | input | 2 | Mode per fault, 1 = cycle-by-cycle, 0 = latched |
| stat_clr | input | 2 | Status-clear request per fault |
| oe_wr | input | 1 | Load strobe for the output enables |
| oe_val | input | 2*NUM_PAIRS | New output-enable value |
| pin_hi | output | NUM_PAIRS | Gated high-side pins |
| pin_lo | output | NUM_PAIRS | Gated low-side pins |
| pin_oe | output | 2*NUM_PAIRS | Pin output enables, 0 = tri-state |
| flt_stat | output | 2 | Fault status flags (bit 0 = A, bit 1 = B) |

## Verification
The bench checks the pins while the fault line has just fallen and before any clock edge. A design that shuts down only through the synchronizer would still drive live PWM there. It tries a latched clear while the line is low, and a period start without a clear. A design with a loose release condition would restore drive in either case. It holds a cycle-by-cycle fault low across a period start, then checks that the flag clears and drive returns at exactly the first period start after the line goes high. It also overlaps a latched fault and a cycle-by-cycle fault, which catches a design that lets one fault's release free the pins while the other fault still holds them.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
   localparam int NUM_FAULTS = 2;
   localparam int FLT_A      = 0;
   localparam int FLT_B      = 1;

   typedef enum logic {
      MODE_LATCHED = 1'b0,
      MODE_CBC     = 1'b1
   } flt_mode_e;
endpackage

// File: rtl/pwm_flt_sync.sv
module pwm_flt_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("pwm_flt_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_flt_channel.sv
module pwm_flt_channel
   import pwm_fault_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      flt_n,
   input  logic      en,
   input  flt_mode_e mode,
   input  logic      clr_req,
   input  logic      period_start,
   output logic      stat,
   output logic      hold,
   output logic      force_now
);
   logic flt_n_s;
   logic flt_low_s;
   logic stat_q;
   logic hold_q;
   logic is_cbc;

   pwm_flt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (flt_n),
      .q    (flt_n_s)
   );

   assign flt_low_s = ~flt_n_s;
   assign is_cbc    = (mode == MODE_CBC);

   // Status flag: set by the synchronized fault, cleared by software
   // (latched) or at a period start (cycle-by-cycle) once the line is high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   stat_q <= 1'b0;
      else if (!en)                                 stat_q <= 1'b0;
      else if (flt_low_s)                           stat_q <= 1'b1;
      else if (is_cbc ? period_start : clr_req)     stat_q <= 1'b0;
   end

   // Hold state: released only on a period boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                           hold_q <= 1'b0;
      else if (!en)                                         hold_q <= 1'b0;
      else if (flt_low_s)                                   hold_q <= 1'b1;
      else if (period_start && (is_cbc || !stat_q))         hold_q <= 1'b0;
   end

   assign stat      = stat_q;
   assign hold      = hold_q & en;
   assign force_now = en & ~flt_n;

   p_latched_clr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !is_cbc && stat_q && flt_low_s) |=> stat_q);

   p_release_on_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_q) |-> ($past(period_start) || !$past(en)));

   p_cbc_autoclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && is_cbc && stat_q && period_start && !flt_low_s) |=> !stat_q);

   p_latched_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !is_cbc && hold_q && stat_q && !clr_req && !flt_low_s) |=> hold_q);
endmodule

// File: rtl/pwm_pin_stage.sv
module pwm_pin_stage #(
   parameter int NUM_PAIRS = 3
) (
   input  logic [NUM_PAIRS-1:0] pwm_hi_in,
   input  logic [NUM_PAIRS-1:0] pwm_lo_in,
   input  logic                 hi_act_low,
   input  logic                 lo_act_low,
   input  logic                 shut,
   output logic [NUM_PAIRS-1:0] pin_hi,
   output logic [NUM_PAIRS-1:0] pin_lo
);
   for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
      assign pin_hi[i] = (pwm_hi_in[i] & ~shut) ^ hi_act_low;
      assign pin_lo[i] = (pwm_lo_in[i] & ~shut) ^ lo_act_low;
   end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
   import pwm_fault_pkg::*;
#(
   parameter int   NUM_PAIRS   = 3,
   parameter int   SYNC_STAGES = 2,
   parameter logic OE_ON_RESET = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_PAIRS-1:0]   pwm_hi_in,
   input  logic [NUM_PAIRS-1:0]   pwm_lo_in,
   input  logic                   period_start,
   input  logic                   hi_act_low,
   input  logic                   lo_act_low,
   input  logic                   flt_a_n,
   input  logic                   flt_b_n,
   input  logic [1:0]             flt_en,
   input  logic [1:0]             flt_cbc,
   input  logic [1:0]             stat_clr,
   input  logic                   oe_wr,
   input  logic [2*NUM_PAIRS-1:0] oe_val,
   output logic [NUM_PAIRS-1:0]   pin_hi,
   output logic [NUM_PAIRS-1:0]   pin_lo,
   output logic [2*NUM_PAIRS-1:0] pin_oe,
   output logic [1:0]             flt_stat
);
   localparam int OE_W = 2 * NUM_PAIRS;
   localparam logic [OE_W-1:0] OE_RST = OE_ON_RESET ? {OE_W{1'b1}} : {OE_W{1'b0}};

   if (NUM_PAIRS < 1 || NUM_PAIRS > 8) begin : g_bad_pairs
      $error("pwm_fault_guard: NUM_PAIRS must be 1..8");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("pwm_fault_guard: SYNC_STAGES must be 2..4");
   end

   logic [NUM_FAULTS-1:0] flt_raw_n;
   logic [NUM_FAULTS-1:0] hold_v;
   logic [NUM_FAULTS-1:0] force_v;
   logic [NUM_FAULTS-1:0] stat_v;
   logic                  shut;
   logic [OE_W-1:0]       oe_q;

   assign flt_raw_n[FLT_A] = flt_a_n;
   assign flt_raw_n[FLT_B] = flt_b_n;

   for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_flt
      pwm_flt_channel #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .flt_n       (flt_raw_n[f]),
         .en          (flt_en[f]),
         .mode        (flt_mode_e'(flt_cbc[f])),
         .clr_req     (stat_clr[f]),
         .period_start(period_start),
         .stat        (stat_v[f]),
         .hold        (hold_v[f]),
         .force_now   (force_v[f])
      );
   end

   assign shut     = |(hold_v | force_v);
   assign flt_stat = stat_v;

   pwm_pin_stage #(.NUM_PAIRS(NUM_PAIRS)) u_pins (
      .pwm_hi_in (pwm_hi_in),
      .pwm_lo_in (pwm_lo_in),
      .hi_act_low(hi_act_low),
      .lo_act_low(lo_act_low),
      .shut      (shut),
      .pin_hi    (pin_hi),
      .pin_lo    (pin_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     oe_q <= OE_RST;
      else if (oe_wr) oe_q <= oe_val;
   end
   assign pin_oe = oe_q;

   p_async_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((flt_en[FLT_A] && !flt_a_n) || (flt_en[FLT_B] && !flt_b_n)) |->
      (pin_hi == {NUM_PAIRS{hi_act_low}} && pin_lo == {NUM_PAIRS{lo_act_low}}));

   p_any_hold_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|hold_v) |-> (pin_hi == {NUM_PAIRS{hi_act_low}} && pin_lo == {NUM_PAIRS{lo_act_low}}));

   p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_en == 2'b00 && $past(flt_en) == 2'b00) |-> (flt_stat == 2'b00));

   p_oe_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      oe_wr |=> (pin_oe == $past(oe_val)));
endmodule

// File: tb/pwm_fault_guard_tb.sv
`timescale 1ns/1ps
module pwm_fault_guard_tb_top;
   localparam int N  = 3;
   localparam int SS = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pwm_hi_in = '0, pwm_lo_in = '0;
   logic         period_start = 1'b0;
   logic         hi_act_low = 1'b0, lo_act_low = 1'b0;
   logic         flt_a_n = 1'b1, flt_b_n = 1'b1;
   logic [1:0]   flt_en = 2'b00, flt_cbc = 2'b00, stat_clr = 2'b00;
   logic         oe_wr = 1'b0;
   logic [2*N-1:0] oe_val = '0;
   logic [N-1:0] pin_hi, pin_lo, pin_hi2, pin_lo2;
   logic [2*N-1:0] pin_oe, pin_oe2;
   logic [1:0]   flt_stat, flt_stat2;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pwm_fault_guard #(.NUM_PAIRS(N), .SYNC_STAGES(SS), .OE_ON_RESET(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
      .period_start(period_start), .hi_act_low(hi_act_low), .lo_act_low(lo_act_low),
      .flt_a_n(flt_a_n), .flt_b_n(flt_b_n), .flt_en(flt_en), .flt_cbc(flt_cbc),
      .stat_clr(stat_clr), .oe_wr(oe_wr), .oe_val(oe_val),
      .pin_hi(pin_hi), .pin_lo(pin_lo), .pin_oe(pin_oe), .flt_stat(flt_stat));

   pwm_fault_guard #(.NUM_PAIRS(N), .SYNC_STAGES(SS), .OE_ON_RESET(1'b1)) dut_pre_i (
      .clk(clk), .rst_n(rst_n), .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
      .period_start(period_start), .hi_act_low(hi_act_low), .lo_act_low(lo_act_low),
      .flt_a_n(1'b1), .flt_b_n(1'b1), .flt_en(2'b00), .flt_cbc(2'b00),
      .stat_clr(2'b00), .oe_wr(1'b0), .oe_val(oe_val),
      .pin_hi(pin_hi2), .pin_lo(pin_lo2), .pin_oe(pin_oe2), .flt_stat(flt_stat2));

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_pins(input string req, input bit blocked);
      logic [N-1:0] eh, el;
      eh = blocked ? {N{hi_act_low}} : (pwm_hi_in ^ {N{hi_act_low}});
      el = blocked ? {N{lo_act_low}} : (pwm_lo_in ^ {N{lo_act_low}});
      check_val({req, " pin_hi"}, 32'(pin_hi), 32'(eh));
      check_val({req, " pin_lo"}, 32'(pin_lo), 32'(el));
   endtask

   task automatic pulse_period();
      period_start = 1'b1;
      step(1);
      period_start = 1'b0;
   endtask

   task automatic pulse_clr(input logic [1:0] which);
      stat_clr = which;
      step(1);
      stat_clr = 2'b00;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1 reset state
      check_val("R1 flt_stat", 32'(flt_stat), 32'h0);
      check_val("R1 pin_oe cleared", 32'(pin_oe), 32'h0);
      check_val("R1 pin_oe preset", 32'(pin_oe2), 32'h3f);
      rst_n = 1'b1;
      step(1);
      oe_val = 6'b101101; oe_wr = 1'b1;
      step(1);
      oe_wr = 1'b0;
      check_val("R1 oe load", 32'(pin_oe), 32'h2d);

      // R2 sweep: every drive pattern under every polarity pair
      for (int p = 0; p < 4; p++) begin
         hi_act_low = p[0]; lo_act_low = p[1];
         for (int v = 0; v < 64; v++) begin
            pwm_hi_in = v[2:0]; pwm_lo_in = v[5:3];
            #1;
            check_pins("R2 normal drive", 1'b0);
         end
      end

      pwm_hi_in = 3'b111; pwm_lo_in = 3'b101; hi_act_low = 1'b0; lo_act_low = 1'b1;

      // R4 disabled fault ignored
      flt_en = 2'b00; flt_a_n = 1'b0; flt_b_n = 1'b0;
      step(5);
      check_pins("R4 disabled fault", 1'b0);
      check_val("R4 flag stays 0", 32'(flt_stat), 32'h0);
      flt_a_n = 1'b1; flt_b_n = 1'b1;
      step(4);

      // R3/R5 latched fault A (R11: bit0 = A, cbc=0 latched)
      flt_en = 2'b01; flt_cbc = 2'b00;
      step(1);
      flt_a_n = 1'b0;
      #0.5;
      check_pins("R3 immediate force", 1'b1);
      step(SS + 1);
      check_val("R5 R11 flag A set", 32'(flt_stat), 32'h1);
      pwm_hi_in = 3'b010; #1;
      check_pins("R3 forced under new drive", 1'b1);
      pwm_hi_in = 3'b111;

      // R6 clear while low is ignored
      pulse_clr(2'b01);
      check_val("R6 flag held", 32'(flt_stat), 32'h1);
      check_pins("R6 still blocked", 1'b1);

      // R8 line high + period start without clear: no release
      flt_a_n = 1'b1;
      step(5);
      pulse_period();
      check_pins("R8 no release without clear", 1'b1);
      check_val("R8 flag still set", 32'(flt_stat), 32'h1);

      // R7 clear then wait for period boundary
      pulse_clr(2'b01);
      check_val("R7 flag cleared", 32'(flt_stat), 32'h0);
      step(3);
      check_pins("R7 blocked until period", 1'b1);
      pulse_period();
      check_pins("R7 resumes at period", 1'b0);

      // R9 cycle-by-cycle fault B
      flt_en = 2'b10; flt_cbc = 2'b10; hi_act_low = 1'b1; lo_act_low = 1'b0;
      step(1);
      flt_b_n = 1'b0;
      step(SS + 1);
      check_val("R9 R11 flag B set", 32'(flt_stat), 32'h2);
      check_pins("R9 blocked while low", 1'b1);
      pulse_period();
      check_pins("R9 blocked across period while low", 1'b1);
      check_val("R9 flag kept while low", 32'(flt_stat), 32'h2);
      flt_b_n = 1'b1;
      step(4);
      check_pins("R9 waits for period", 1'b1);
      check_val("R9 flag until period", 32'(flt_stat), 32'h2);
      pulse_period();
      check_val("R9 auto clear", 32'(flt_stat), 32'h0);
      check_pins("R9 resumes", 1'b0);

      // R10 both faults: A latched, B cycle-by-cycle
      flt_en = 2'b11; flt_cbc = 2'b10;
      step(1);
      flt_a_n = 1'b0; flt_b_n = 1'b0;
      step(4);
      check_val("R10 both flags", 32'(flt_stat), 32'h3);
      flt_b_n = 1'b1;
      step(4);
      pulse_period();
      check_val("R10 B cleared A held", 32'(flt_stat), 32'h1);
      check_pins("R10 A still blocks", 1'b1);
      flt_a_n = 1'b1;
      step(4);
      pulse_period();
      check_pins("R10 A needs clear", 1'b1);
      pulse_clr(2'b01);
      pulse_period();
      check_pins("R10 all released", 1'b0);
      check_val("R10 flags clear", 32'(flt_stat), 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule